// File: doc/BRIEF.md
# Time Source Selector with Holdover

This block sits behind two time-code decoders: one fed by the pulse-width (DC) form of the serial time code and one fed by the modulated-carrier (AC) form. Each decoder hands over a time-of-year word, a valid flag and a one-clock second pulse. The block picks one reference, giving fixed priority to the DC path. It forwards that reference's second pulse and time as its own output, together with a code that names the source in use and a flag that marks free-running operation.

Time is kept locally in a counter-driven time keeper. At every accepted reference pulse the keeper is reloaded with the reference time, which names the second that has just begun. The local phase counter then restarts. When no reference pulse arrives for a full second, the phase counter generates the pulse itself and the keeper advances seconds, minutes, hours and day of year on its own. A minimum pulse spacing of half a second keeps a change of source from producing a pulse right after another.

Top module: `tsel_top`

Time words on every port use this layout: bits [5:0] seconds (0-59), bits [11:6] minutes (0-59), bits [16:12] hours (0-23), bits [25:17] day of year (1-365, or 1-366 in a leap year).

## Requirements
- R1: `src_sel` shows 2'b01 when `dc_valid` is high, 2'b10 when only `ac_valid` is high and 2'b00 when neither is high. The code follows the flags with one clock of delay, and 2'b11 never appears.
- R2: Only the second pulse of the source chosen in R1 is a reference pulse. When a reference pulse is accepted, `out_pps` is high in the next clock and `out_tod` equals that source's time word in the same clock. A pulse from the source that was not chosen has no effect on `out_pps` or `out_tod`.
- R3: With no accepted reference pulse, `out_pps` repeats every CLK_HZ clocks, and each of these pulses advances `out_tod` by exactly one second.
- R4: After an accepted reference pulse, the next self-generated pulse comes CLK_HZ clocks after it, unless another reference pulse is accepted first. If a reference pulse coincides with the internal wrap, the reference wins: the time is loaded, not incremented.
- R5: The one-second advance rolls seconds 59 to 0 into minutes, minutes 59 to 0 into hours, and hours 23 to 0 into the day of year.
- R6: Day of year wraps to 1 after 365 when `leap_year` is 0, and after 366 when `leap_year` is 1.
- R7: `out_pps` is one clock wide. A reference pulse that arrives fewer than CLK_HZ/2 clocks after the previous output pulse is ignored: there is no output pulse and no load. A pulse exactly CLK_HZ/2 clocks after the previous one is accepted.
- R8: `holdover` is 0 after reset. It becomes 1 together with a self-generated pulse and returns to 0 together with an accepted reference pulse.
- R9: While reset is asserted, `out_pps` is 0, `src_sel` is 2'b00, `holdover` is 0 and `out_tod` is day 1, 00:00:00.
- R10: The first reference pulse after reset is accepted whatever its spacing from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset |
| dc_valid | input | 1 | DC-path decoder has a good time word |
| dc_pps | input | 1 | DC-path second pulse, one clock wide |
| dc_tod | input | 26 | DC-path time word |
| ac_valid | input | 1 | AC-path decoder has a good time word |
| ac_pps | input | 1 | AC-path second pulse, one clock wide |
| ac_tod | input | 26 | AC-path time word |
| leap_year | input | 1 | Current year has 366 days |
| out_tod | output | 26 | Selected or locally kept time |
| out_pps | output | 1 | Output second pulse, one clock wide |
| src_sel | output | 2 | Source in use: 00 holdover, 01 DC, 10 AC |
| holdover | output | 1 | Last second was generated locally |

## Verification
The time keeper is swept over time words near every carry point (seconds 55-59, minutes 58-59, hours 22-23, days 1, 365 and 366) with both leap settings. Each word is loaded from a reference and then advanced once in holdover, so the results tell a correct carry chain apart from one that drops or misplaces a carry. A run of seventy holdover seconds checks the steady one-second cadence across a minute rollover. Reference pulses are placed at spacings of 0, 8, 9, 12 and 19 clocks after the last output pulse. These separate the reset exception, the rejection window, its exact edge, normal reload and a collision with the internal wrap. Valid-flag combinations with pulses from both sources, or from the non-chosen source only, tell the fixed priority apart from any first-come choice.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DOY_W = 9;
  localparam int TOD_W = SEC_W + MIN_W + HR_W + DOY_W;

  typedef struct packed {
    logic [DOY_W-1:0] doy;
    logic [HR_W-1:0]  hour;
    logic [MIN_W-1:0] min;
    logic [SEC_W-1:0] sec;
  } tod_t;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'b00,
    SRC_DC   = 2'b01,
    SRC_AC   = 2'b10
  } src_e;

  localparam tod_t TOD_RESET = '{doy: DOY_W'(1), hour: '0, min: '0, sec: '0};

  // Advance a time word by one second with carry into day of year.
  function automatic tod_t tod_inc(input tod_t t, input logic leap);
    tod_t r;
    logic [DOY_W-1:0] last_day;
    r        = t;
    last_day = leap ? DOY_W'(366) : DOY_W'(365);
    if (t.sec >= SEC_W'(59)) begin
      r.sec = '0;
      if (t.min >= MIN_W'(59)) begin
        r.min = '0;
        if (t.hour >= HR_W'(23)) begin
          r.hour = '0;
          if (t.doy >= last_day) r.doy = DOY_W'(1);
          else                   r.doy = t.doy + DOY_W'(1);
        end else begin
          r.hour = t.hour + HR_W'(1);
        end
      end else begin
        r.min = t.min + MIN_W'(1);
      end
    end else begin
      r.sec = t.sec + SEC_W'(1);
    end
    return r;
  endfunction

endpackage

// File: rtl/tsel_rst_sync.sv
module tsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/tsel_src_arb.sv
module tsel_src_arb
  import tsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dc_valid,
  input  logic dc_pps,
  input  tod_t dc_tod,
  input  logic ac_valid,
  input  logic ac_pps,
  input  tod_t ac_tod,
  output logic ref_pps,
  output tod_t ref_tod,
  output src_e src_o
);

  src_e sel;
  src_e src_q;

  always_comb begin
    if (dc_valid)      sel = SRC_DC;
    else if (ac_valid) sel = SRC_AC;
    else               sel = SRC_HOLD;
  end

  always_comb begin
    case (sel)
      SRC_DC: begin
        ref_pps = dc_pps;
        ref_tod = dc_tod;
      end
      SRC_AC: begin
        ref_pps = ac_pps;
        ref_tod = ac_tod;
      end
      default: begin
        ref_pps = 1'b0;
        ref_tod = dc_tod;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_HOLD;
    else        src_q <= sel;
  end

  assign src_o = src_q;

  // R2
  hold_no_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_valid && !ac_valid) |-> !ref_pps);

endmodule

// File: rtl/tsel_phase.sv
module tsel_phase #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pps,
  output logic take_o,
  output logic wrap_o,
  output logic pps_o,
  output logic hold_o
);

  localparam int CW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 2;
  localparam logic [CW-1:0] LAST    = CW'(CLK_HZ - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLK_HZ / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          hold_q, hold_d;
  logic          pps_q;
  logic          gap_ok, take, wrap, fire;

  always_comb begin
    gap_ok = armed_q || (cnt_q >= HALF_M1);
    take   = ref_pps && gap_ok;
    wrap   = !take && (cnt_q == LAST);
    fire   = take || wrap;
  end

  always_comb begin
    cnt_d   = fire ? '0 : cnt_q + CW'(1);
    armed_d = armed_q && !fire;
    hold_d  = hold_q;
    if (take)      hold_d = 1'b0;
    else if (wrap) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      hold_q  <= 1'b0;
      pps_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      hold_q  <= hold_d;
      pps_q   <= fire;
    end
  end

  assign take_o = take;
  assign wrap_o = wrap;
  assign pps_o  = pps_q;
  assign hold_o = hold_q;

  // R4
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt_q == '0));

  // R8
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !hold_o);

endmodule

// File: rtl/tsel_keeper.sv
module tsel_keeper
  import tsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic wrap_i,
  input  tod_t ref_tod,
  input  logic leap,
  output tod_t tod_o
);

  tod_t tod_q, tod_d;

  always_comb begin
    tod_d = tod_q;
    if (take_i)      tod_d = ref_tod;
    else if (wrap_i) tod_d = tod_inc(tod_q, leap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tod_q <= TOD_RESET;
    else        tod_q <= tod_d;
  end

  assign tod_o = tod_q;

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (tod_o == $past(ref_tod)));

  // R6
  doy_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !leap && tod_q.doy == DOY_W'(365) && tod_q.hour == HR_W'(23)
     && tod_q.min == MIN_W'(59) && tod_q.sec == SEC_W'(59))
    |=> (tod_o.doy == DOY_W'(1)));

  // R5
  sec_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && tod_q.sec == SEC_W'(59)) |=> (tod_o.sec == '0));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !wrap_i) |=> $stable(tod_o));

endmodule

// File: rtl/tsel_top.sv
module tsel_top
  import tsel_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dc_valid,
  input  logic             dc_pps,
  input  logic [TOD_W-1:0] dc_tod,
  input  logic             ac_valid,
  input  logic             ac_pps,
  input  logic [TOD_W-1:0] ac_tod,
  input  logic             leap_year,
  output logic [TOD_W-1:0] out_tod,
  output logic             out_pps,
  output logic [1:0]       src_sel,
  output logic             holdover
);

  logic rst_s_n;
  logic ref_pps, take, wrap;
  tod_t ref_tod, tod;
  src_e src;

  tsel_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  tsel_src_arb i_src_arb (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .dc_valid (dc_valid),
    .dc_pps   (dc_pps),
    .dc_tod   (tod_t'(dc_tod)),
    .ac_valid (ac_valid),
    .ac_pps   (ac_pps),
    .ac_tod   (tod_t'(ac_tod)),
    .ref_pps  (ref_pps),
    .ref_tod  (ref_tod),
    .src_o    (src)
  );

  tsel_phase #(.CLK_HZ(CLK_HZ)) i_phase (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ref_pps (ref_pps),
    .take_o  (take),
    .wrap_o  (wrap),
    .pps_o   (out_pps),
    .hold_o  (holdover)
  );

  tsel_keeper i_keeper (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .take_i  (take),
    .wrap_i  (wrap),
    .ref_tod (ref_tod),
    .leap    (leap_year),
    .tod_o   (tod)
  );

  assign out_tod = TOD_W'(tod);
  assign src_sel = src;

  // R1
  dc_prio_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    dc_valid |=> (src_sel == 2'b01));

  // R1
  src_code_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    src_sel != 2'b11);

  // R7
  pps_width_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_pps |=> !out_pps);

  // R8
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(holdover) |-> out_pps);

endmodule

// File: tb/test_tsel_top.sv
module test_tsel_top;

  localparam int HZ = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dc_valid, dc_pps, ac_valid, ac_pps, leap_year;
  logic [25:0] dc_tod, ac_tod, out_tod;
  logic        out_pps, holdover;
  logic [1:0]  src_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tsel_top #(.CLK_HZ(HZ)) i_tsel_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .dc_valid  (dc_valid),
    .dc_pps    (dc_pps),
    .dc_tod    (dc_tod),
    .ac_valid  (ac_valid),
    .ac_pps    (ac_pps),
    .ac_tod    (ac_tod),
    .leap_year (leap_year),
    .out_tod   (out_tod),
    .out_pps   (out_pps),
    .src_sel   (src_sel),
    .holdover  (holdover)
  );

  function automatic logic [25:0] mk(int d, int h, int m, int s);
    return {9'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  function automatic logic [25:0] plus1(logic [25:0] t, bit leap);
    int d    = int'(t[25:17]);
    int h    = int'(t[16:12]);
    int m    = int'(t[11:6]);
    int s    = int'(t[5:0]);
    int days = leap ? 366 : 365;
    int tot  = (((d - 1) * 24 + h) * 60 + m) * 60 + s + 1;
    tot = tot % (days * 86400);
    return mk(tot / 86400 + 1, (tot / 3600) % 24, (tot / 60) % 60, tot % 60);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_pps && n < 100);
  endtask

  task automatic send_ref(int k, bit dcp, bit acp);
    repeat (k) @(negedge clk);
    dc_pps = dcp;
    ac_pps = acp;
    @(negedge clk);
    dc_pps = 1'b0;
    ac_pps = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [25:0] t, prev;
    rst_n = 1'b0; dc_valid = 0; dc_pps = 0; ac_valid = 0; ac_pps = 0;
    leap_year = 0; dc_tod = '0; ac_tod = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 pps", 32'(out_pps), 0);
    chk("R9 src", 32'(src_sel), 0);
    chk("R9 hold", 32'(holdover), 0);
    chk("R9 tod", 32'(out_tod), 32'(mk(1, 0, 0, 0)));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 / R1 / R2: first reference right after reset
    ac_valid = 1; ac_tod = mk(10, 5, 6, 7);
    @(negedge clk);
    chk("R1 ac only", 32'(src_sel), 2);
    send_ref(0, 0, 1);
    chk("R10 first pps", 32'(out_pps), 1);
    chk("R2 load ac", 32'(out_tod), 32'(mk(10, 5, 6, 7)));
    chk("R8 hold low", 32'(holdover), 0);

    // R3 / R4 / R8: no further reference pulses
    wait_pulse(n);
    chk("R4 restart gap", 32'(n), HZ);
    chk("R3 advance", 32'(out_tod), 32'(mk(10, 5, 6, 8)));
    chk("R8 hold set", 32'(holdover), 1);
    wait_pulse(n);
    chk("R3 period", 32'(n), HZ);
    chk("R3 advance2", 32'(out_tod), 32'(mk(10, 5, 6, 9)));

    // R7: early reference ignored, edge of window accepted
    ac_tod = mk(20, 1, 2, 3);
    send_ref(8, 0, 1);
    chk("R7 early no pps", 32'(out_pps), 0);
    chk("R7 early no load", 32'(out_tod), 32'(mk(10, 5, 6, 9)));
    wait_pulse(n);
    chk("R7 wrap after ignore", 32'(n), HZ - 9);
    send_ref(9, 0, 1);
    chk("R7 half accepted", 32'(out_pps), 1);
    chk("R7 half load", 32'(out_tod), 32'(mk(20, 1, 2, 3)));
    chk("R8 hold clear", 32'(holdover), 0);
    @(negedge clk);
    chk("R7 width", 32'(out_pps), 0);

    // R1 / R2: priority to DC
    dc_valid = 1; dc_tod = mk(30, 4, 4, 4); ac_tod = mk(40, 8, 8, 8);
    @(negedge clk);
    chk("R1 dc priority", 32'(src_sel), 1);
    wait_pulse(n);
    send_ref(12, 1, 1);
    chk("R2 both pps", 32'(out_pps), 1);
    chk("R2 dc chosen", 32'(out_tod), 32'(mk(30, 4, 4, 4)));
    wait_pulse(n);
    send_ref(12, 0, 1);
    chk("R2 ac ignored pps", 32'(out_pps), 0);
    chk("R2 ac ignored tod", 32'(out_tod), 32'(mk(30, 4, 4, 5)));

    // R4: reference coinciding with internal wrap
    wait_pulse(n);
    dc_tod = mk(50, 12, 0, 0);
    send_ref(19, 1, 0);
    chk("R4 collide pps", 32'(out_pps), 1);
    chk("R4 collide load", 32'(out_tod), 32'(mk(50, 12, 0, 0)));
    wait_pulse(n);
    chk("R4 collide gap", 32'(n), HZ);

    // R1: flag combinations
    dc_valid = 0; ac_valid = 1;
    @(negedge clk);
    chk("R1 dc drop", 32'(src_sel), 2);
    ac_valid = 0;
    @(negedge clk);
    chk("R1 none", 32'(src_sel), 0);
    dc_valid = 1;
    @(negedge clk);
    chk("R1 dc only", 32'(src_sel), 1);
    dc_valid = 0;

    // R5 / R6: sweep near carry points
    for (int lp = 0; lp < 2; lp++) begin
      for (int di = 0; di < 3; di++) begin
        for (int h = 22; h < 24; h++) begin
          for (int m = 58; m < 60; m++) begin
            for (int s = 55; s < 60; s++) begin
              int d = (di == 0) ? 1 : ((di == 1) ? 365 : 366);
              if (d == 366 && lp == 0) continue;
              leap_year = lp[0];
              t = mk(d, h, m, s);
              wait_pulse(n);
              dc_valid = 1; dc_tod = t;
              send_ref(12, 1, 0);
              chk("R2 sweep load", 32'(out_tod), 32'(t));
              dc_valid = 0;
              wait_pulse(n);
              chk("R3 sweep gap", 32'(n), HZ);
              if (d >= 365) chk("R6 day carry", 32'(out_tod), 32'(plus1(t, lp[0])));
              else          chk("R5 carry", 32'(out_tod), 32'(plus1(t, lp[0])));
              chk("R8 sweep hold", 32'(holdover), 1);
              chk("R1 sweep src", 32'(src_sel), 0);
            end
          end
        end
      end
    end

    // R3 / R5: long holdover run across a minute
    leap_year = 0;
    prev = out_tod;
    for (int i = 0; i < 70; i++) begin
      wait_pulse(n);
      chk("R3 run gap", 32'(n), HZ);
      chk("R5 run tod", 32'(out_tod), 32'(plus1(prev, 1'b0)));
      prev = plus1(prev, 1'b0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule